// File: doc/BRIEF.md
# Read Data Latency Pipeline for a Synchronous DRAM Data Path

This block times the read data of a 16-bit synchronous DRAM. Each cycle in which a read beat is issued, the word fetched from the array enters a short register pipeline together with a valid flag. The beat is driven onto the data outputs after the programmed column-access latency, which is either two or three clock cycles. A per-byte output enable goes with the data. The same pipeline can serve as the timing reference for a controller that checks returning read data.

Each byte of the output has its own mask input. A mask takes effect two internal clock edges after it is sampled, and this delay does not depend on the latency setting. When clock enable is sampled low, the following internal edge is swallowed. The beat pipeline, the mask pipeline and the outputs all hold their state through that edge, and any inputs presented for it are lost. The latency setting may change only when no beat is in flight.

Top module: `rdp_read_pipe`

## Requirements
- R1: After reset, both byte enables on `dq_oe` are 0 and `dq_out` is 0.
- R2: With `cl_sel`=0 (latency two), a beat issued with `rd_beat`=1 at an active edge n appears on `dq_out` with both enables high after edge n+1. It stays there until edge n+2.
- R3: With `cl_sel`=1 (latency three), a beat issued at an active edge n appears after edge n+2 and stays there until edge n+3.
- R4: Beats issued on consecutive active edges come out in issue order on consecutive cycles, and the enable stays high without a gap.
- R5: The enable falls in the cycle after the last beat unless another beat follows directly. Two beats separated by one idle edge give enable high, low, high.
- R6: A mask level sampled at active edge k governs the output that is driven after the next active edge, whatever the latency. A high mask clears that byte's enable.
- R7: `dqm_hi` masks only bits 15:8 and enable bit 1. `dqm_lo` masks only bits 7:0 and enable bit 0.
- R8: When `cke` is sampled low at edge k, edge k+1 is suspended. The outputs, the beat pipeline and the mask pipeline keep their values, and `rd_beat`, `arr_data` and the masks presented for edge k+1 have no effect.
- R9: `cl_sel` changes only while no beat is in flight in the pipeline.
- R10: A byte whose enable is low reads as 0 on `dq_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Clock enable; a low sample suspends the next internal edge |
| rd_beat | input | 1 | A read beat is issued this cycle |
| cl_sel | input | 1 | Latency select: 0 gives two cycles, 1 gives three |
| dqm_hi | input | 1 | Mask for the upper byte |
| dqm_lo | input | 1 | Mask for the lower byte |
| arr_data | input | 16 | Array word that accompanies the issued beat |
| dq_out | output | 16 | Read data; a disabled byte reads as 0 |
| dq_oe | output | 2 | Byte output enables (bit 1 upper, bit 0 lower) |

## Verification
The checker watches four things on every cycle. A disabled byte is always zero. The outputs hold across a suspended edge. The enable of a byte is never high when its mask was high two unsuspended edges earlier. An unmasked latency-two beat always reaches the output on time. It also flags any latency change while beats are in flight. Other behaviour can only be shown by the bench's directed scenarios: exact data order in a burst, the latency-three timing, the mask offset under latency three, the loss of a read issued during a suspended edge, and a suspend that lands mid-flight.

// File: rtl/rdp_pkg.sv
package rdp_pkg;

    localparam int LANE_W     = 8;
    localparam int LANES      = 2;
    localparam int DQ_W       = LANE_W * LANES;
    localparam int MIN_CL     = 2;
    localparam int MAX_CL     = 3;
    localparam int PIPE_DEPTH = MAX_CL;
    localparam int MASK_DELAY = 2;

    typedef logic [DQ_W-1:0]  dq_word_t;
    typedef logic [LANES-1:0] lane_vec_t;

    typedef struct packed {
        logic     vld;
        dq_word_t data;
    } beat_t;

    typedef enum logic {
        CL_TWO   = 1'b0,
        CL_THREE = 1'b1
    } cl_mode_t;

    // Stage whose register drives the pins for the chosen latency.
    function automatic int tap_of(cl_mode_t mode);
        return (mode == CL_THREE) ? (MAX_CL - 1) : (MIN_CL - 1);
    endfunction

    // Zero every byte lane whose enable is low.
    function automatic dq_word_t lane_gate(dq_word_t word, lane_vec_t en);
        dq_word_t res;
        for (int i = 0; i < LANES; i++) begin
            res[i*LANE_W +: LANE_W] = en[i] ? word[i*LANE_W +: LANE_W] : '0;
        end
        return res;
    endfunction

endpackage

// File: rtl/rdp_suspend_gate.sv
module rdp_suspend_gate (
    input  logic clk,
    input  logic rst,
    input  logic cke,
    output logic adv
);
    // A low clock-enable sample removes the following internal edge.
    always_ff @(posedge clk) begin
        if (rst) adv <= 1'b1;
        else     adv <= cke;
    end
endmodule

// File: rtl/rdp_beat_pipe.sv
module rdp_beat_pipe
    import rdp_pkg::*;
#(
    parameter int DEPTH = PIPE_DEPTH
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    adv,
    input  beat_t                   beat_in,
    output beat_t [DEPTH-1:0]       stage,
    output logic                    idle
);
    always_ff @(posedge clk) begin
        if (rst) begin
            stage <= '0;
        end else if (adv) begin
            stage[0] <= beat_in;
            for (int i = 1; i < DEPTH; i++) begin
                stage[i] <= stage[i-1];
            end
        end
    end

    always_comb begin
        idle = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            if (stage[i].vld) idle = 1'b0;
        end
    end
endmodule

// File: rtl/rdp_mask_pipe.sv
module rdp_mask_pipe
    import rdp_pkg::*;
#(
    parameter int DELAY = MASK_DELAY
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      adv,
    input  lane_vec_t mask_in,
    output lane_vec_t mask_out
);
    lane_vec_t mq [DELAY];

    // Fixed delay, independent of the latency setting; frozen with the beats.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DELAY; i++) mq[i] <= '1;
        end else if (adv) begin
            mq[0] <= mask_in;
            for (int i = 1; i < DELAY; i++) mq[i] <= mq[i-1];
        end
    end

    assign mask_out = mq[DELAY-1];
endmodule

// File: rtl/rdp_lane_drive.sv
module rdp_lane_drive
    import rdp_pkg::*;
(
    input  beat_t     tap,
    input  lane_vec_t mask,
    output lane_vec_t oe,
    output dq_word_t  dq
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign oe[g] = tap.vld & ~mask[g];
    end

    assign dq = lane_gate(tap.data, oe);
endmodule

// File: rtl/rdp_read_pipe.sv
module rdp_read_pipe
    import rdp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cke,
    input  logic              rd_beat,
    input  logic              cl_sel,
    input  logic              dqm_hi,
    input  logic              dqm_lo,
    input  logic [DQ_W-1:0]   arr_data,
    output logic [DQ_W-1:0]   dq_out,
    output logic [LANES-1:0]  dq_oe
);
    logic                   adv;
    logic                   pipe_idle;
    beat_t                  beat_in;
    beat_t [PIPE_DEPTH-1:0] stage;
    beat_t                  tap;
    lane_vec_t              mask_in;
    lane_vec_t              mask_now;

    assign beat_in = '{vld: rd_beat, data: arr_data};
    assign mask_in = {dqm_hi, dqm_lo};

    rdp_suspend_gate u_gate (
        .clk (clk),
        .rst (rst),
        .cke (cke),
        .adv (adv)
    );

    rdp_beat_pipe #(.DEPTH(PIPE_DEPTH)) u_beats (
        .clk     (clk),
        .rst     (rst),
        .adv     (adv),
        .beat_in (beat_in),
        .stage   (stage),
        .idle    (pipe_idle)
    );

    rdp_mask_pipe #(.DELAY(MASK_DELAY)) u_masks (
        .clk      (clk),
        .rst      (rst),
        .adv      (adv),
        .mask_in  (mask_in),
        .mask_out (mask_now)
    );

    always_comb begin
        tap = stage[tap_of(cl_mode_t'(cl_sel))];
    end

    rdp_lane_drive u_drive (
        .tap  (tap),
        .mask (mask_now),
        .oe   (dq_oe),
        .dq   (dq_out)
    );
endmodule

// File: rtl/rdp_read_pipe_chk.sv
module rdp_read_pipe_chk
    import rdp_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cke,
    input logic             rd_beat,
    input logic             cl_sel,
    input logic             dqm_lo,
    input logic [DQ_W-1:0]  dq_out,
    input logic [LANES-1:0] dq_oe,
    input logic             pipe_idle
);
    // R10: a disabled lower byte reads as zero
    assert_undriven_zero_R10: assert property (@(posedge clk) disable iff (rst)
        !dq_oe[0] |-> dq_out[LANE_W-1:0] == '0);

    // R8: outputs unchanged across the suspended edge
    assert_suspend_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !cke |-> ##2 ($stable(dq_out) && $stable(dq_oe)));

    // R6: enable never high when the mask two unsuspended edges back was high
    assert_mask_two_R6: assert property (@(posedge clk) disable iff (rst)
        (dq_oe[0] && $past(cke, 2) && $past(cke, 3)) |-> !$past(dqm_lo, 2));

    // R2: unmasked latency-two beat reaches the pins on time
    assert_cl2_latency_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_beat && $past(cke) && cke && !cl_sel && !dqm_lo) |=> ##1 dq_oe[0]);

    // R9: latency changes only with the pipeline empty
    assert_cl_change_empty_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(cl_sel) |-> pipe_idle);
endmodule

bind rdp_read_pipe rdp_read_pipe_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cke       (cke),
    .rd_beat   (rd_beat),
    .cl_sel    (cl_sel),
    .dqm_lo    (dqm_lo),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe),
    .pipe_idle (pipe_idle)
);

// File: tb/rdp_read_pipe_bench.sv
module rdp_read_pipe_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cke = 1'b1;
    logic        rd_beat = 1'b0;
    logic        cl_sel = 1'b0;
    logic        dqm_hi = 1'b0;
    logic        dqm_lo = 1'b0;
    logic [15:0] arr_data = '0;
    logic [15:0] dq_out;
    logic [1:0]  dq_oe;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    rdp_read_pipe u_rdp_read_pipe (
        .clk      (clk),
        .rst      (rst),
        .cke      (cke),
        .rd_beat  (rd_beat),
        .cl_sel   (cl_sel),
        .dqm_hi   (dqm_hi),
        .dqm_lo   (dqm_lo),
        .arr_data (arr_data),
        .dq_out   (dq_out),
        .dq_oe    (dq_oe)
    );

    // Present inputs for the next edge, then observe just after it.
    task automatic cyc(input logic rd, input logic [15:0] d,
                       input logic mh, input logic ml, input logic ck);
        rd_beat  = rd;
        arr_data = d;
        dqm_hi   = mh;
        dqm_lo   = ml;
        cke      = ck;
        @(posedge clk);
        #1;
    endtask

    task automatic idle1();
        cyc(1'b0, 16'h0000, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic chk(input string req, input logic [1:0] oe_exp,
                       input logic [15:0] dq_exp);
        checks++;
        if (dq_oe !== oe_exp || dq_out !== dq_exp) begin
            errors++;
            $display("FAIL %s: oe=%b dq=%h expected oe=%b dq=%h",
                     req, dq_oe, dq_out, oe_exp, dq_exp);
        end
    endtask

    task automatic drain_and_set(input logic cl);
        for (int i = 0; i < 4; i++) idle1();
        cl_sel = cl;
        idle1();
    endtask

    task automatic t_reset();
        chk("R1 reset", 2'b00, 16'h0000);
    endtask

    task automatic t_cl2_single();
        drain_and_set(1'b0);
        cyc(1'b1, 16'hA1B2, 1'b0, 1'b0, 1'b1); chk("R2 cl2 early", 2'b00, 16'h0000);
        idle1();                               chk("R2 cl2 data", 2'b11, 16'hA1B2);
        idle1();                               chk("R5 cl2 drop", 2'b00, 16'h0000);
    endtask

    task automatic t_cl3_single();
        drain_and_set(1'b1);
        cyc(1'b1, 16'hC3D4, 1'b0, 1'b0, 1'b1); chk("R3 cl3 early0", 2'b00, 16'h0000);
        idle1();                               chk("R3 cl3 early1", 2'b00, 16'h0000);
        idle1();                               chk("R3 cl3 data", 2'b11, 16'hC3D4);
        idle1();                               chk("R5 cl3 drop", 2'b00, 16'h0000);
    endtask

    task automatic t_burst_cl2();
        logic [15:0] w [4] = '{16'h1111, 16'h2222, 16'h3333, 16'h4444};
        drain_and_set(1'b0);
        cyc(1'b1, w[0], 1'b0, 1'b0, 1'b1); chk("R4 burst lead", 2'b00, 16'h0000);
        for (int i = 1; i < 4; i++) begin
            cyc(1'b1, w[i], 1'b0, 1'b0, 1'b1);
            chk("R4 burst beat", 2'b11, w[i-1]);
        end
        idle1(); chk("R4 burst last", 2'b11, w[3]);
        idle1(); chk("R5 burst end", 2'b00, 16'h0000);
    endtask

    task automatic t_mask_cl2();
        drain_and_set(1'b0);
        cyc(1'b1, 16'hAB12, 1'b0, 1'b1, 1'b1); chk("R6 mask lead", 2'b00, 16'h0000);
        cyc(1'b1, 16'hCD34, 1'b1, 1'b0, 1'b1); chk("R7 lo masked", 2'b10, 16'hAB00);
        cyc(1'b1, 16'hEF56, 1'b1, 1'b1, 1'b1); chk("R7 hi masked", 2'b01, 16'h0034);
        cyc(1'b1, 16'h9876, 1'b0, 1'b0, 1'b1); chk("R10 both masked", 2'b00, 16'h0000);
        idle1();                               chk("R6 unmasked", 2'b11, 16'h9876);
        idle1();                               chk("R5 mask end", 2'b00, 16'h0000);
    endtask

    task automatic t_mask_cl3();
        drain_and_set(1'b1);
        cyc(1'b1, 16'h5A6B, 1'b0, 1'b0, 1'b1); chk("R6 cl3 m0", 2'b00, 16'h0000);
        cyc(1'b1, 16'h7C8D, 1'b0, 1'b1, 1'b1); chk("R6 cl3 m1", 2'b00, 16'h0000);
        cyc(1'b0, 16'h0000, 1'b1, 1'b0, 1'b1); chk("R6 cl3 lo offset", 2'b10, 16'h5A00);
        idle1();                               chk("R6 cl3 hi offset", 2'b01, 16'h008D);
        idle1();                               chk("R5 cl3 mask end", 2'b00, 16'h0000);
    endtask

    task automatic t_suspend_cl2();
        drain_and_set(1'b0);
        cyc(1'b1, 16'hBEEF, 1'b0, 1'b0, 1'b1); chk("R8 pre", 2'b00, 16'h0000);
        cyc(1'b0, 16'h0000, 1'b0, 1'b0, 1'b0); chk("R8 data out", 2'b11, 16'hBEEF);
        cyc(1'b1, 16'hDEAD, 1'b1, 1'b1, 1'b1); chk("R8 held", 2'b11, 16'hBEEF);
        idle1();                               chk("R8 resume", 2'b00, 16'h0000);
        idle1();                               chk("R8 read ignored", 2'b00, 16'h0000);
        idle1();                               chk("R8 read ignored2", 2'b00, 16'h0000);
    endtask

    task automatic t_suspend_cl3();
        drain_and_set(1'b1);
        cyc(1'b1, 16'h0F1E, 1'b0, 1'b0, 1'b0); chk("R8 cl3 issue", 2'b00, 16'h0000);
        idle1();                               chk("R8 cl3 frozen", 2'b00, 16'h0000);
        idle1();                               chk("R8 cl3 stage", 2'b00, 16'h0000);
        idle1();                               chk("R8 cl3 late data", 2'b11, 16'h0F1E);
        idle1();                               chk("R8 cl3 end", 2'b00, 16'h0000);
    endtask

    task automatic t_gap_cl2();
        drain_and_set(1'b0);
        cyc(1'b1, 16'h1357, 1'b0, 1'b0, 1'b1); chk("R5 gap lead", 2'b00, 16'h0000);
        idle1();                               chk("R5 gap first", 2'b11, 16'h1357);
        cyc(1'b1, 16'h2468, 1'b0, 1'b0, 1'b1); chk("R5 gap low", 2'b00, 16'h0000);
        idle1();                               chk("R5 gap second", 2'b11, 16'h2468);
        idle1();                               chk("R5 gap end", 2'b00, 16'h0000);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_cl2_single();
        t_cl3_single();
        t_burst_cl2();
        t_mask_cl2();
        t_mask_cl3();
        t_suspend_cl2();
        t_suspend_cl3();
        t_gap_cl2();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end
endmodule